// File: doc/BRIEF.md
# Multicycle CPU Control Sequencer

This block is the control core of a small 16-bit register machine. A fixed four-phase loop drives it: it reads the next instruction word from memory, then latches it and advances the program counter, then decodes it, then carries it out. After that it goes back to the read phase. Every instruction takes exactly four clock cycles, and only one instruction is active at any time. There is no overlap between instructions.

The sequencer works from one instruction register. From that register it controls a sixteen-entry register file, a two-operand ALU, a three-way write-back selector and a single-port synchronous memory. The memory address comes from one of two places: the program counter during instruction fetch, or the instruction's 8-bit address field for data transfers. The register-file write enables, the 2-bit write-back select, the 4-bit ALU code and the current phase are brought out as ports so that the surrounding chip can observe the sequencing. Four status flags are also brought out.

The memory outside the block must return read data one cycle after `mem_re` is sampled high. It must commit a write on the edge where `mem_we` is sampled high.

Top module: `cpu_seq_core`

## Requirements
- R1: `phase` steps 0 (fetch), 1 (latch and PC increment), 2 (decode), 3 (execute), then back to 0. It advances exactly once per clock once reset has been released.
- R2: Reset, whether asserted or released through the two-flop synchronizer, sets all of the following: phase 0, program counter 0, flags 0, all sixteen registers 0, and no register write.
- R3: In phase 0 the block drives `mem_re`=1, `mem_we`=0 and `mem_addr`=PC. The word returned is latched into the instruction register in phase 1, and in that same phase the PC increments by one, modulo 256.
- R4: Instruction fields are: bits [15:12] op-code, [11:8] destination register, [7:4] source A, [3:0] source B. For load, store and load-immediate, bits [7:0] hold an address or an immediate. The op-codes are 1 add, 2 subtract, 3 and, 4 or, 5 xor, 8 load, 9 store, 10 load-immediate.
- R5: An ALU instruction writes the result of A op B into the destination register. During phase 3, `alu_op` equals the op-code and `wb_sel`=00. In every other case `alu_op` is 0.
- R6: Load issues a memory read at address bits [7:0] in phase 2. In phase 3 it writes the returned word into the destination register with `wb_sel`=01. `mem_re` and `mem_we` are never high together.
- R7: Load-immediate writes bits [7:0], zero-extended to 16 bits, into the destination register, with `wb_sel`=10.
- R8: Store drives `mem_we`=1, `mem_addr`=bits [7:0] and `mem_wdata`=the destination register's value, in phase 3 only. It writes no register.
- R9: `rf_we_onehot` is all zero except during phase 3 of a register-writing instruction. In that cycle exactly bit [destination] is set. `wb_sel`=11 is reserved: it is never emitted, and it would write nothing.
- R10: `flags` is {V,C,N,Z} in bits [3:0], and it changes only on the edge that ends phase 3 of an ALU instruction. The flags are set as follows:
  - Z: the result is zero.
  - N: result bit 15.
  - C: for add, the carry out; for subtract, the borrow (A < B unsigned); for logic operations, 0.
  - V: signed overflow for add and subtract; 0 for logic operations.
- R11: Any other op-code is a no-op: no register write, no memory access, flags kept. The loop returns to phase 0.
- R12: The ALU operands are the register values from before the instruction. This holds when the destination register is also a source register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mem_addr | output | 8 | Memory address: PC on fetch, bits [7:0] on data access |
| mem_re | output | 1 | Memory read strobe, data expected next cycle |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 16 | Store data |
| mem_rdata | input | 16 | Read data, one cycle after `mem_re` |
| phase | output | 2 | Current instruction-cycle phase |
| alu_op | output | 4 | ALU operation code in execute |
| wb_sel | output | 2 | Write-back source select |
| rf_we_onehot | output | 16 | Decoded register write enables |
| flags | output | 4 | Status flags {V,C,N,Z} |

## Verification
Several things happen together in phase 3 of an ALU instruction whose destination is one of its own sources. The register file reads the operand, writes the new value into that same register, and updates the flags, all on a single edge. The stimulus produces this on purpose. A directed xor overwrites its own source, and random instructions copy the destination field into source A a quarter of the time. A bench model computes the result from the register values before the instruction. The result is judged through the flags seen in the next fetch, and through later store data, which is labelled as the self-reference case.

// File: rtl/cpu_seq_pkg.sv
package cpu_seq_pkg;
  localparam int DATA_W  = 16;
  localparam int MADDR_W = 8;
  localparam int RSEL_W  = 4;
  localparam int OPC_W   = 4;
  localparam int FLAG_W  = 4;
  localparam int NREG    = 1 << RSEL_W;
  localparam int IMM_W   = MADDR_W;

  localparam int FLG_Z = 0;
  localparam int FLG_N = 1;
  localparam int FLG_C = 2;
  localparam int FLG_V = 3;

  typedef enum logic [1:0] {
    PH_FETCH  = 2'd0,
    PH_INCR   = 2'd1,
    PH_DECODE = 2'd2,
    PH_EXEC   = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    WB_ALU  = 2'd0,
    WB_MEM  = 2'd1,
    WB_IMM  = 2'd2,
    WB_RSVD = 2'd3
  } wbsel_e;

  localparam logic [OPC_W-1:0] OP_ADD   = 4'd1;
  localparam logic [OPC_W-1:0] OP_SUB   = 4'd2;
  localparam logic [OPC_W-1:0] OP_AND   = 4'd3;
  localparam logic [OPC_W-1:0] OP_OR    = 4'd4;
  localparam logic [OPC_W-1:0] OP_XOR   = 4'd5;
  localparam logic [OPC_W-1:0] OP_LOAD  = 4'd8;
  localparam logic [OPC_W-1:0] OP_STORE = 4'd9;
  localparam logic [OPC_W-1:0] OP_LDI   = 4'd10;
endpackage

// File: rtl/cpu_seq_fsm.sv
module cpu_seq_fsm
  import cpu_seq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [DATA_W-1:0]     mem_rdata,
  output phase_e                phase_o,
  output logic [MADDR_W-1:0]    mem_addr_o,
  output logic                  mem_re_o,
  output logic                  mem_we_o,
  output logic [OPC_W-1:0]      alu_op_o,
  output wbsel_e                wb_sel_o,
  output logic                  wr_en_o,
  output logic                  flag_en_o,
  output logic [RSEL_W-1:0]     dst_o,
  output logic [RSEL_W-1:0]     srca_o,
  output logic [RSEL_W-1:0]     srcb_o,
  output logic [IMM_W-1:0]      imm_o
);
  phase_e              phase_q, phase_d;
  logic [MADDR_W-1:0]  pc_q, pc_d;
  logic [DATA_W-1:0]   ir_q, ir_d;
  logic                ir_ld;
  logic [OPC_W-1:0]    opc;

  assign opc    = ir_q[DATA_W-1 -: OPC_W];
  assign dst_o  = ir_q[DATA_W-OPC_W-1 -: RSEL_W];
  assign srca_o = ir_q[2*RSEL_W-1 -: RSEL_W];
  assign srcb_o = ir_q[RSEL_W-1:0];
  assign imm_o  = ir_q[IMM_W-1:0];
  assign phase_o = phase_q;

  // next state: phase loop, IR/PC load enable
  always_comb begin
    phase_d = phase_e'(phase_q + 2'd1);
    ir_ld   = (phase_q == PH_INCR);
    pc_d    = pc_q + 1'b1;
    ir_d    = mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_FETCH;
      pc_q    <= '0;
      ir_q    <= '0;
    end else begin
      phase_q <= phase_d;
      if (ir_ld) begin
        ir_q <= ir_d;
        pc_q <= pc_d;
      end
    end
  end

  // control decode per phase
  always_comb begin
    mem_addr_o = pc_q;
    mem_re_o   = 1'b0;
    mem_we_o   = 1'b0;
    alu_op_o   = '0;
    wb_sel_o   = WB_ALU;
    wr_en_o    = 1'b0;
    flag_en_o  = 1'b0;
    case (phase_q)
      PH_FETCH: mem_re_o = 1'b1;
      PH_DECODE: begin
        if (opc == OP_LOAD) begin
          mem_re_o   = 1'b1;
          mem_addr_o = imm_o;
        end
      end
      PH_EXEC: begin
        case (opc)
          OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR: begin
            alu_op_o  = opc;
            wr_en_o   = 1'b1;
            flag_en_o = 1'b1;
          end
          OP_LOAD: begin
            wb_sel_o = WB_MEM;
            wr_en_o  = 1'b1;
          end
          OP_LDI: begin
            wb_sel_o = WB_IMM;
            wr_en_o  = 1'b1;
          end
          OP_STORE: begin
            mem_we_o   = 1'b1;
            mem_addr_o = imm_o;
          end
          default: ;
        endcase
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/cpu_sel_decoder.sv
module cpu_sel_decoder #(
  parameter int SEL_W = 4,
  localparam int N_OUT = 1 << SEL_W
) (
  input  logic              en,
  input  logic [SEL_W-1:0]  sel,
  output logic [N_OUT-1:0]  onehot
);
  for (genvar i = 0; i < N_OUT; i++) begin : g_line
    assign onehot[i] = en && (sel == SEL_W'(i));
  end
endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile
  import cpu_seq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NREG-1:0]     we_oh,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [RSEL_W-1:0]   ra,
  input  logic [RSEL_W-1:0]   rb,
  input  logic [RSEL_W-1:0]   rc,
  output logic [DATA_W-1:0]   rd_a,
  output logic [DATA_W-1:0]   rd_b,
  output logic [DATA_W-1:0]   rd_c
);
  logic [NREG-1:0][DATA_W-1:0] regs;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (we_oh[i]) q <= wdata;
    end
    assign regs[i] = q;
  end

  assign rd_a = regs[ra];
  assign rd_b = regs[rb];
  assign rd_c = regs[rc];
endmodule

// File: rtl/cpu_alu.sv
module cpu_alu
  import cpu_seq_pkg::*;
(
  input  logic [OPC_W-1:0]   op,
  input  logic [DATA_W-1:0]  a,
  input  logic [DATA_W-1:0]  b,
  output logic [DATA_W-1:0]  res,
  output logic [FLAG_W-1:0]  flg
);
  logic [DATA_W:0] wide;
  logic            sa, sb, sr;

  always_comb begin
    wide = '0;
    flg  = '0;
    case (op)
      OP_ADD:  wide = {1'b0, a} + {1'b0, b};
      OP_SUB:  wide = {1'b0, a} - {1'b0, b};
      OP_AND:  wide = {1'b0, a & b};
      OP_OR:   wide = {1'b0, a | b};
      OP_XOR:  wide = {1'b0, a ^ b};
      default: wide = '0;
    endcase
    res = wide[DATA_W-1:0];
    sa  = a[DATA_W-1];
    sb  = b[DATA_W-1];
    sr  = res[DATA_W-1];
    flg[FLG_Z] = (res == '0);
    flg[FLG_N] = sr;
    if (op == OP_ADD) begin
      flg[FLG_C] = wide[DATA_W];
      flg[FLG_V] = (sa == sb) && (sr != sa);
    end else if (op == OP_SUB) begin
      flg[FLG_C] = wide[DATA_W];
      flg[FLG_V] = (sa != sb) && (sr != sa);
    end
  end
endmodule

// File: rtl/cpu_seq_core.sv
module cpu_seq_core
  import cpu_seq_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  output logic [7:0]   mem_addr,
  output logic         mem_re,
  output logic         mem_we,
  output logic [15:0]  mem_wdata,
  input  logic [15:0]  mem_rdata,
  output logic [1:0]   phase,
  output logic [3:0]   alu_op,
  output logic [1:0]   wb_sel,
  output logic [15:0]  rf_we_onehot,
  output logic [3:0]   flags
);
  logic [1:0]          sync_q;
  logic                rst_sync_n;
  phase_e              ph;
  wbsel_e              wsel;
  logic                wr_en, flag_en, dec_en;
  logic [RSEL_W-1:0]   dst, srca, srcb;
  logic [IMM_W-1:0]    imm;
  logic [NREG-1:0]     we_oh;
  logic [DATA_W-1:0]   op_a, op_b, op_c, alu_res, wb_data;
  logic [FLAG_W-1:0]   alu_flg, flags_q;
  logic [OPC_W-1:0]    aop;

  // reset: asserted asynchronously, released after two clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_sync_n = sync_q[1];

  cpu_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_sync_n), .mem_rdata(mem_rdata),
    .phase_o(ph), .mem_addr_o(mem_addr), .mem_re_o(mem_re), .mem_we_o(mem_we),
    .alu_op_o(aop), .wb_sel_o(wsel), .wr_en_o(wr_en), .flag_en_o(flag_en),
    .dst_o(dst), .srca_o(srca), .srcb_o(srcb), .imm_o(imm)
  );

  // reserved select never opens a write line
  assign dec_en = wr_en && (wsel != WB_RSVD);

  cpu_sel_decoder #(.SEL_W(RSEL_W)) u_dec (
    .en(dec_en), .sel(dst), .onehot(we_oh)
  );

  cpu_regfile u_rf (
    .clk(clk), .rst_n(rst_sync_n), .we_oh(we_oh), .wdata(wb_data),
    .ra(srca), .rb(srcb), .rc(dst),
    .rd_a(op_a), .rd_b(op_b), .rd_c(op_c)
  );

  cpu_alu u_alu (
    .op(aop), .a(op_a), .b(op_b), .res(alu_res), .flg(alu_flg)
  );

  always_comb begin
    case (wsel)
      WB_ALU:  wb_data = alu_res;
      WB_MEM:  wb_data = mem_rdata;
      WB_IMM:  wb_data = {{(DATA_W-IMM_W){1'b0}}, imm};
      default: wb_data = op_c;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  flags_q <= '0;
    else if (flag_en) flags_q <= alu_flg;
  end

  assign mem_wdata    = op_c;
  assign phase        = ph;
  assign alu_op       = aop;
  assign wb_sel       = wsel;
  assign rf_we_onehot = we_oh;
  assign flags        = flags_q;
endmodule

// File: rtl/cpu_seq_checker.sv
module cpu_seq_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  phase,
  input logic        mem_re,
  input logic        mem_we,
  input logic [1:0]  wb_sel,
  input logic [15:0] rf_we,
  input logic [3:0]  flags
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assert_phase_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> (phase == $past(phase) + 2'd1));

  assert_fetch_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd0) |-> (mem_re && !mem_we));

  assert_mem_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we));

  assert_store_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (phase == 2'd3 && rf_we == 16'd0));

  assert_we_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we != 16'd0) |-> (phase == 2'd3 && wb_sel != 2'b11 && $countones(rf_we) == 1));

  assert_flags_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && phase != 2'd3) |=> $stable(flags));
endmodule

bind cpu_seq_core cpu_seq_checker u_chk (
  .clk(clk), .rst_n(rst_sync_n), .phase(phase), .mem_re(mem_re),
  .mem_we(mem_we), .wb_sel(wb_sel), .rf_we(rf_we_onehot), .flags(flags)
);

// File: tb/tb_cpu_seq_core.sv
module tb_cpu_seq_core;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic [7:0]  mem_addr;
  logic        mem_re, mem_we;
  logic [15:0] mem_wdata, mem_rdata;
  logic [1:0]  phase, wb_sel;
  logic [3:0]  alu_op, flags;
  logic [15:0] rf_we_onehot;

  cpu_seq_core dut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_re(mem_re),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .phase(phase), .alu_op(alu_op), .wb_sel(wb_sel),
    .rf_we_onehot(rf_we_onehot), .flags(flags)
  );

  // memory with one-cycle read latency and a preload path
  logic [15:0] mem [256];
  logic [15:0] rdata_q;
  logic        pl_we;
  logic [7:0]  pl_addr;
  logic [15:0] pl_data;
  always @(posedge clk) begin
    if (pl_we) mem[pl_addr] <= pl_data;
    else if (mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_re) rdata_q <= mem[mem_addr];
  end
  assign mem_rdata = rdata_q;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // reference model state
  logic [15:0] m_reg [16];
  logic [15:0] m_mem [256];
  logic [3:0]  m_flags;
  logic [7:0]  m_pc;
  bit          m_self [16];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] enc(input logic [3:0] op, input logic [3:0] d,
                                      input logic [3:0] a, input logic [3:0] b);
    return {op, d, a, b};
  endfunction

  function automatic logic [15:0] encm(input logic [3:0] op, input logic [3:0] d, input logic [7:0] ad);
    return {op, d, ad};
  endfunction

  function automatic bit is_alu(input logic [3:0] op);
    return op >= 4'd1 && op <= 4'd5;
  endfunction

  // {flags V C N Z, result}
  function automatic logic [19:0] alu_model(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b);
    logic [16:0] w;
    logic [15:0] r;
    logic        c, v;
    c = 1'b0; v = 1'b0;
    case (op)
      4'd1: begin w = {1'b0, a} + {1'b0, b}; r = w[15:0]; c = w[16];
              v = (a[15] == b[15]) && (r[15] != a[15]); end
      4'd2: begin r = a - b; c = (a < b); v = (a[15] != b[15]) && (r[15] != a[15]); end
      4'd3: r = a & b;
      4'd4: r = a | b;
      default: r = a ^ b;
    endcase
    return {v, c, r[15], (r == 16'd0), r};
  endfunction

  task automatic preload_all();
    for (int i = 0; i < 256; i++) begin
      pl_we = 1'b1; pl_addr = 8'(i); pl_data = m_mem[i];
      @(negedge clk);
    end
    pl_we = 1'b0;
  endtask

  task automatic model_reset();
    for (int i = 0; i < 16; i++) begin m_reg[i] = 16'd0; m_self[i] = 1'b0; end
    m_flags = 4'd0;
    m_pc = 8'd0;
  endtask

  task automatic check_reset_state();
    chk(phase == 2'd0, "R2 phase", 32'(phase), 0);
    chk(flags == 4'd0, "R2 flags", 32'(flags), 0);
    chk(rf_we_onehot == 16'd0, "R2 rf_we", 32'(rf_we_onehot), 0);
    chk(mem_re && !mem_we && mem_addr == 8'd0, "R2 pc", {mem_re, mem_we, mem_addr}, 32'h200);
  endtask

  task automatic run_instr();
    logic [15:0] ir, exp_we;
    logic [3:0]  op, d, a, b;
    logic [7:0]  ad;
    logic [19:0] fr;
    string       stag;
    ir = m_mem[m_pc];
    op = ir[15:12]; d = ir[11:8]; a = ir[7:4]; b = ir[3:0]; ad = ir[7:0];
    // fetch
    chk(phase == 2'd0, "R1 fetch phase", 32'(phase), 0);
    chk(mem_re && !mem_we && mem_addr == m_pc, "R3 fetch addr", {mem_re, mem_we, mem_addr}, {2'b10, m_pc});
    chk(flags == m_flags, "R10 flags", 32'(flags), 32'(m_flags));
    @(negedge clk);
    chk(phase == 2'd1, "R1 incr phase", 32'(phase), 1);
    @(negedge clk);
    chk(phase == 2'd2, "R1 decode phase", 32'(phase), 2);
    if (op == 4'd8)
      chk(mem_re && !mem_we && mem_addr == ad, "R6 R4 load addr", {mem_re, mem_we, mem_addr}, {2'b10, ad});
    else
      chk(!mem_we, "R11 decode no write", 32'(mem_we), 0);
    @(negedge clk);
    chk(phase == 2'd3, "R1 exec phase", 32'(phase), 3);
    exp_we = (is_alu(op) || op == 4'd8 || op == 4'd10) ? (16'd1 << d) : 16'd0;
    chk(rf_we_onehot == exp_we, "R9 rf_we", 32'(rf_we_onehot), 32'(exp_we));
    chk(wb_sel != 2'b11, "R9 wb_sel reserved", 32'(wb_sel), 0);
    if (is_alu(op)) begin
      chk(alu_op == op && wb_sel == 2'd0, "R5 R4 alu ctrl", {alu_op, wb_sel}, {op, 2'd0});
      fr = alu_model(op, m_reg[a], m_reg[b]);
      m_reg[d] = fr[15:0];
      m_flags = fr[19:16];
      m_self[d] = (d == a) || (d == b);
    end else begin
      chk(alu_op == 4'd0, "R5 alu_op idle", 32'(alu_op), 0);
      if (op == 4'd8) begin
        chk(wb_sel == 2'd1, "R6 wb_sel", 32'(wb_sel), 1);
        m_reg[d] = m_mem[ad]; m_self[d] = 1'b0;
      end else if (op == 4'd10) begin
        chk(wb_sel == 2'd2, "R7 wb_sel", 32'(wb_sel), 2);
        m_reg[d] = {8'd0, ad}; m_self[d] = 1'b0;
      end else if (op == 4'd9) begin
        stag = m_self[d] ? "R12 self-ref store" : "R8 store";
        chk(mem_we && !mem_re && mem_addr == ad, "R8 store strobe", {mem_we, mem_re, mem_addr}, {2'b10, ad});
        chk(mem_wdata == m_reg[d], stag, 32'(mem_wdata), 32'(m_reg[d]));
        m_mem[ad] = m_reg[d];
      end else begin
        chk(!mem_we && !mem_re, "R11 no-op mem", {mem_we, mem_re}, 0);
      end
    end
    if (op != 4'd9) chk(!mem_we, "R8 no stray write", 32'(mem_we), 0);
    m_pc = m_pc + 8'd1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  int unsigned seedv;
  initial begin
    logic [3:0] op, d, a, b;
    int k;
    seedv = $urandom(32'h5EED1234);
    rst_n = 1'b0; pl_we = 1'b0; pl_addr = '0; pl_data = '0;
    for (int i = 0; i < 256; i++) m_mem[i] = 16'(($urandom));
    m_mem[8'h80] = 16'h7FFF; m_mem[8'h81] = 16'h0001; m_mem[8'h82] = 16'hFFFF;
    k = 0;
    m_mem[k++] = encm(4'd8, 4'd1, 8'h80);
    m_mem[k++] = encm(4'd8, 4'd2, 8'h81);
    m_mem[k++] = enc(4'd1, 4'd3, 4'd1, 4'd2);   // signed overflow to 0x8000
    m_mem[k++] = encm(4'd8, 4'd4, 8'h82);
    m_mem[k++] = enc(4'd1, 4'd5, 4'd4, 4'd2);   // carry out, zero
    m_mem[k++] = enc(4'd2, 4'd6, 4'd2, 4'd4);   // borrow
    m_mem[k++] = enc(4'd2, 4'd7, 4'd1, 4'd1);   // zero
    m_mem[k++] = encm(4'd10, 4'd8, 8'hFF);      // zero-extend
    m_mem[k++] = 16'hF123;                      // unknown op-code
    m_mem[k++] = enc(4'd5, 4'd1, 4'd1, 4'd8);   // destination is a source
    m_mem[k++] = encm(4'd9, 4'd1, 8'h90);
    m_mem[k++] = enc(4'd2, 4'd9, 4'd3, 4'd2);   // 0x8000-1 overflow
    m_mem[k++] = encm(4'd9, 4'd9, 8'h91);
    m_mem[k++] = enc(4'd3, 4'd10, 4'd4, 4'd8);
    m_mem[k++] = enc(4'd4, 4'd11, 4'd3, 4'd8);
    m_mem[k++] = encm(4'd9, 4'd10, 8'h92);
    m_mem[k++] = encm(4'd9, 4'd11, 8'h93);
    m_mem[k++] = encm(4'd9, 4'd8, 8'h94);
    while (k < 120) begin
      d = 4'($urandom); a = 4'($urandom); b = 4'($urandom);
      if (($urandom % 4) == 0) a = d;
      case ($urandom % 10)
        0: op = 4'd1; 1: op = 4'd2; 2: op = 4'd3; 3: op = 4'd4; 4: op = 4'd5;
        5: op = 4'd8; 6, 7: op = 4'd9; 8: op = 4'd10;
        default: begin
          op = 4'($urandom);
          if (op inside {4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd8, 4'd9, 4'd10}) op = 4'd6;
        end
      endcase
      if (op == 4'd8 || op == 4'd9) m_mem[k++] = encm(op, d, {1'b1, a[2:0], b});
      else m_mem[k++] = enc(op, d, a, b);
    end
    model_reset();
    @(negedge clk);
    preload_all();
    check_reset_state();
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < 120; i++) run_instr();

    // second reset mid-run: registers must come back as zero
    rst_n = 1'b0;
    @(negedge clk);
    check_reset_state();
    m_mem[0] = encm(4'd9, 4'd3, 8'hA5);
    m_mem[1] = encm(4'd9, 4'd1, 8'hA6);
    pl_we = 1'b1; pl_addr = 8'd0; pl_data = m_mem[0];
    @(negedge clk);
    pl_addr = 8'd1; pl_data = m_mem[1];
    @(negedge clk);
    pl_we = 1'b0;
    model_reset();
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    run_instr();
    run_instr();
    chk(mem[8'hA5] == 16'd0, "R2 reg cleared", 32'(mem[8'hA5]), 0);
    chk(mem[8'hA6] == 16'd0, "R2 reg cleared", 32'(mem[8'hA6]), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule